// File: doc/BRIEF.md
# Serial Storage Access Bridge

This block sits between a byte-wide processor bus and a bit-serial storage memory that is owned by a separate sequencing controller. The processor addresses two locations. One holds a small mode register. The other is the data port. A write to the data port loads a byte for transfer into memory. A read from the data port asks for a byte out of memory. Either access marks a transfer as pending and lets go of a shared, wired-low request line. That line can then float high, which tells the memory owner that service is wanted.

The memory owner answers by pulling the request line low while its sync signal is also low. Only that combination produces the active-low grant. While grant is asserted, the block moves one bit per clock, least significant bit first. On a read it assembles incoming memory bits into a parallel byte. On a write it serialises the stored byte onto the memory data line. When the max-hold function is active, the outgoing bit comes from the external max-hold comparison path instead. A transfer is always eight bits. Grant and the request are then dropped together. A completed read also produces a one-cycle pulse that steps the memory owner's address counter.

Top module: `stor_bus_bridge`

## Requirements
- R1: After reset, grant_n_o=1, req_release_o=0, addr_incr_o=0, mem_ser_o=0, bus_rdata_o=0, peak_force_n_o=1, avg_force_n_o=1, mode_o=0 and max_hold_o=0.
- R2: Address decoding is applied to bus accesses. A write at CTRL_ADDR (default 2) loads the mode register on the next edge. DATA_ADDR (default 3) is the data port. An access to any other address changes no output.
- R3: Mode register bit 1 drives peak_force_n_o low and bit 2 drives avg_force_n_o low. mode_o reports 1 (peak) when bit 1 is set, whatever bit 2 holds. It reports 2 (average) when only bit 2 is set, and 0 (normal) otherwise.
- R4: max_hold_o is high exactly when mode register bit 0 is set and valid_i is high.
- R5: A data-port write or read with no transfer pending raises req_release_o on the next edge.
- R6: Grant (grant_n_o low) starts on the edge after one at which a transfer is pending, req_line_i is low and sync_i is low. A low request line with sync_i high does not grant.
- R7: Grant lasts exactly eight cycles. At its end, req_release_o falls on the same edge.
- R8: On a read, mem_ser_i is sampled on each granted edge, least significant bit first. The assembled byte appears on bus_rdata_o as grant ends.
- R9: On a write, mem_ser_o carries the written byte least significant bit first, one bit per granted cycle. Outside a write grant it is 0.
- R10: During a write grant with max_hold_o high, mem_ser_o follows mh_ser_i instead of the stored byte.
- R11: addr_incr_o pulses for exactly one cycle as a read grant ends. It never pulses after a write.
- R12: Data-port strobes that arrive while a transfer is pending are ignored. The pending transfer keeps its direction and byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W | Processor bus address |
| bus_wr_i | input | 1 | Processor write strobe |
| bus_rd_i | input | 1 | Processor read strobe |
| bus_wdata_i | input | DATA_W | Processor write data |
| bus_rdata_o | output | DATA_W | Last byte read from memory |
| valid_i | input | 1 | Sweep-valid qualifier from the memory owner |
| peak_force_n_o | output | 1 | Low forces peak operation |
| avg_force_n_o | output | 1 | Low, with peak not forced, forces average operation |
| mode_o | output | 2 | Decoded mode: 0 normal, 1 peak, 2 average |
| max_hold_o | output | 1 | Max-hold command to the comparison path |
| req_release_o | output | 1 | High lets the shared request line float high |
| req_line_i | input | 1 | Observed level of the shared request line |
| sync_i | input | 1 | Sync from the memory owner, active low |
| grant_n_o | output | 1 | Memory access grant, active low |
| mem_ser_i | input | 1 | Serial data from memory |
| mh_ser_i | input | 1 | Serial data from the max-hold path |
| mem_ser_o | output | 1 | Serial data to memory |
| addr_incr_o | output | 1 | One-cycle address step after a read |

## Verification
The bench holds the request line low with sync high and checks that no grant appears. A design that used the line alone would start shifting early. It counts granted cycles and checks that the request drops on the eighth, so a transfer one bit too short or too long shows up as a wrong byte or a late release. It issues a second data write, and then a read, while a write is still pending. A design that latched these would send the wrong byte or leave an address step behind. It also checks that the address step follows reads only, and that the max-hold source takes over the serial output.

// File: rtl/sbb_pkg.sv
package sbb_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_PEAK   = 2'd1,
        MODE_AVG    = 2'd2
    } mode_e;

    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } dir_e;

endpackage

// File: rtl/sbb_decode.sv
module sbb_decode #(
    parameter int unsigned ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 2,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 3
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    output logic              ctl_wr_o,
    output logic              dat_wr_o,
    output logic              dat_rd_o
);

    logic hit_ctl;
    logic hit_dat;

    always_comb begin
        hit_ctl  = (addr_i == CTRL_ADDR);
        hit_dat  = (addr_i == DATA_ADDR);
        ctl_wr_o = wr_i & hit_ctl;
        dat_wr_o = wr_i & hit_dat;
        dat_rd_o = rd_i & hit_dat & ~wr_i;
    end

endmodule

// File: rtl/sbb_ctrl.sv
module sbb_ctrl
    import sbb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr_i,
    input  logic       mh_bit_i,
    input  logic       pk_bit_i,
    input  logic       av_bit_i,
    input  logic       valid_i,
    output logic       peak_force_n_o,
    output logic       avg_force_n_o,
    output mode_e      mode_o,
    output logic       max_hold_o
);

    typedef struct packed {
        logic mh;
        logic pk;
        logic av;
    } ctl_st_t;

    ctl_st_t st_d;
    ctl_st_t st_q;

    always_comb begin
        st_d = st_q;
        if (ctl_wr_i) begin
            st_d.mh = mh_bit_i;
            st_d.pk = pk_bit_i;
            st_d.av = av_bit_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        peak_force_n_o = ~st_q.pk;
        avg_force_n_o  = ~st_q.av;
        if (!peak_force_n_o) begin
            mode_o = MODE_PEAK;
        end else if (!avg_force_n_o) begin
            mode_o = MODE_AVG;
        end else begin
            mode_o = MODE_NORMAL;
        end
        max_hold_o = st_q.mh & valid_i;
    end

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_i |=> (peak_force_n_o == !$past(pk_bit_i)) && (avg_force_n_o == !$past(av_bit_i))); // R3
    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr_i |=> $stable(peak_force_n_o) && $stable(avg_force_n_o)); // R2

endmodule

// File: rtl/sbb_xfer.sv
module sbb_xfer
    import sbb_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dat_wr_i,
    input  logic              dat_rd_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              req_line_i,
    input  logic              sync_i,
    input  logic              mem_ser_i,
    input  logic              mh_ser_i,
    input  logic              max_hold_i,
    output logic              req_release_o,
    output logic              grant_n_o,
    output logic              mem_ser_o,
    output logic              addr_incr_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        logic              pend;
        logic              gnt;
        dir_e              dir;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] wsh;
        logic [DATA_W-1:0] rsh;
        logic [DATA_W-1:0] rdat;
        logic              incr;
    } xf_st_t;

    xf_st_t st_d;
    xf_st_t st_q;
    logic [DATA_W-1:0] rsh_next;
    logic              grant_ok;

    always_comb begin
        st_d     = st_q;
        st_d.incr = 1'b0;
        rsh_next = {mem_ser_i, st_q.rsh[DATA_W-1:1]};
        grant_ok = ~req_line_i & ~sync_i;
        if (!st_q.pend) begin
            if (dat_wr_i) begin
                st_d.pend = 1'b1;
                st_d.dir  = DIR_WR;
                st_d.wsh  = wdata_i;
            end else if (dat_rd_i) begin
                st_d.pend = 1'b1;
                st_d.dir  = DIR_RD;
            end
        end else if (!st_q.gnt) begin
            if (grant_ok) begin
                st_d.gnt = 1'b1;
                st_d.cnt = '0;
            end
        end else begin
            st_d.rsh = rsh_next;
            if (st_q.cnt == LAST) begin
                st_d.gnt  = 1'b0;
                st_d.pend = 1'b0;
                st_d.cnt  = '0;
                if (st_q.dir == DIR_RD) begin
                    st_d.rdat = rsh_next;
                    st_d.incr = 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        req_release_o = st_q.pend;
        grant_n_o     = ~st_q.gnt;
        addr_incr_o   = st_q.incr;
        rdata_o       = st_q.rdat;
        if (st_q.gnt && (st_q.dir == DIR_WR)) begin
            mem_ser_o = max_hold_i ? mh_ser_i : st_q.wsh[st_q.cnt];
        end else begin
            mem_ser_o = 1'b0;
        end
    end

    AST_REQ_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_release_o) |-> $past(dat_wr_i || dat_rd_i)); // R5
    AST_GRANT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(grant_n_o) |-> $past(!req_line_i && !sync_i)); // R6
    AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_n_o |-> req_release_o); // R6
    AST_GRANT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_n_o && st_q.cnt == LAST) |=> (grant_n_o && !req_release_o)); // R7
    AST_INCR_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        addr_incr_o |-> $past(!grant_n_o)); // R11
    AST_SER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        grant_n_o |-> !mem_ser_o); // R9

endmodule

// File: rtl/stor_bus_bridge.sv
module stor_bus_bridge
    import sbb_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 2,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              valid_i,
    output logic              peak_force_n_o,
    output logic              avg_force_n_o,
    output logic [1:0]        mode_o,
    output logic              max_hold_o,
    output logic              req_release_o,
    input  logic              req_line_i,
    input  logic              sync_i,
    output logic              grant_n_o,
    input  logic              mem_ser_i,
    input  logic              mh_ser_i,
    output logic              mem_ser_o,
    output logic              addr_incr_o
);

    localparam int unsigned MH_BIT = 0;
    localparam int unsigned PK_BIT = 1;
    localparam int unsigned AV_BIT = 2;

    logic  ctl_wr;
    logic  dat_wr;
    logic  dat_rd;
    mode_e mode_w;
    logic  mh_w;

    sbb_decode #(
        .ADDR_W   (ADDR_W),
        .CTRL_ADDR(CTRL_ADDR),
        .DATA_ADDR(DATA_ADDR)
    ) decode_i (
        .addr_i  (bus_addr_i),
        .wr_i    (bus_wr_i),
        .rd_i    (bus_rd_i),
        .ctl_wr_o(ctl_wr),
        .dat_wr_o(dat_wr),
        .dat_rd_o(dat_rd)
    );

    sbb_ctrl ctrl_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctl_wr_i      (ctl_wr),
        .mh_bit_i      (bus_wdata_i[MH_BIT]),
        .pk_bit_i      (bus_wdata_i[PK_BIT]),
        .av_bit_i      (bus_wdata_i[AV_BIT]),
        .valid_i       (valid_i),
        .peak_force_n_o(peak_force_n_o),
        .avg_force_n_o (avg_force_n_o),
        .mode_o        (mode_w),
        .max_hold_o    (mh_w)
    );

    sbb_xfer #(
        .DATA_W(DATA_W)
    ) xfer_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .dat_wr_i     (dat_wr),
        .dat_rd_i     (dat_rd),
        .wdata_i      (bus_wdata_i),
        .req_line_i   (req_line_i),
        .sync_i       (sync_i),
        .mem_ser_i    (mem_ser_i),
        .mh_ser_i     (mh_ser_i),
        .max_hold_i   (mh_w),
        .req_release_o(req_release_o),
        .grant_n_o    (grant_n_o),
        .mem_ser_o    (mem_ser_o),
        .addr_incr_o  (addr_incr_o),
        .rdata_o      (bus_rdata_o)
    );

    always_comb begin
        mode_o     = mode_w;
        max_hold_o = mh_w;
    end

    AST_MH_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        max_hold_o |-> valid_i); // R4

endmodule

// File: tb/stor_bus_bridge_tb_top.sv
module stor_bus_bridge_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       valid = 1'b0;
    logic       peak_n, avg_n, max_hold, req_rel, grant_n, mem_ser_o, incr;
    logic [1:0] mode;
    logic       far_pull = 1'b0;
    logic       sync = 1'b1;
    logic       mem_ser_i = 1'b0;
    logic       mh_ser = 1'b0;
    logic       req_line;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] rd_q[$];
    logic [7:0] wr_q[$];

    always #2 clk = ~clk;

    assign req_line = req_rel & ~far_pull;

    stor_bus_bridge dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_addr_i(bus_addr), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .valid_i(valid), .peak_force_n_o(peak_n), .avg_force_n_o(avg_n),
        .mode_o(mode), .max_hold_o(max_hold), .req_release_o(req_rel),
        .req_line_i(req_line), .sync_i(sync), .grant_n_o(grant_n),
        .mem_ser_i(mem_ser_i), .mh_ser_i(mh_ser), .mem_ser_o(mem_ser_o),
        .addr_incr_o(incr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr_op(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_rd_op(input logic [3:0] a, input logic [7:0] exp_byte);
        rd_q.push_back(exp_byte);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Memory owner model: grants, moves 8 bits, checks the end of transfer.
    task automatic serve(input logic [7:0] rbits, input logic is_rd);
        logic [7:0] wbits;
        wbits = '0;
        far_pull = 1'b1; sync = 1'b0;
        @(negedge clk);
        check("R6 grant after line and sync low", grant_n, 1'b0);
        for (int k = 0; k < 8; k++) begin
            check("R7 grant held", grant_n, 1'b0);
            mem_ser_i = rbits[k];
            wbits[k]  = mem_ser_o;
            @(negedge clk);
        end
        check("R7 grant released after 8", grant_n, 1'b1);
        check("R7 request dropped", req_rel, 1'b0);
        check("R11 incr only on read", incr, is_rd);
        if (!is_rd) begin
            if (wr_q.size() == 0) begin
                check("R9 write scoreboard empty", 1, 0);
            end else begin
                check("R9 serial write byte", wbits, wr_q.pop_front());
            end
        end
        far_pull = 1'b0; sync = 1'b1; mem_ser_i = 1'b0;
        @(negedge clk);
        check("R11 incr single cycle", incr, 1'b0);
    endtask

    // Monitor: pops expected read bytes when the address step appears.
    always @(negedge clk) begin
        if (rst_n && incr) begin
            if (rd_q.size() == 0) begin
                check("R11 unexpected address step", 1, 0);
            end else begin
                check("R8 read byte", bus_rdata, rd_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 grant_n", grant_n, 1'b1);
        check("R1 req_release", req_rel, 1'b0);
        check("R1 incr", incr, 1'b0);
        check("R1 ser_out", mem_ser_o, 1'b0);
        check("R1 rdata", bus_rdata, 8'h00);
        check("R1 peak_n", peak_n, 1'b1);
        check("R1 avg_n", avg_n, 1'b1);
        check("R1 mode", mode, 2'd0);
        check("R1 max_hold", max_hold, 1'b0);

        // R2 / R3
        bus_wr_op(4'h2, 8'h02);
        check("R3 peak forced", peak_n, 1'b0);
        check("R3 mode peak", mode, 2'd1);
        bus_wr_op(4'h2, 8'h06);
        check("R3 both set, avg_n", avg_n, 1'b0);
        check("R3 both set, mode peak", mode, 2'd1);
        bus_wr_op(4'h2, 8'h04);
        check("R3 average peak_n high", peak_n, 1'b1);
        check("R3 mode average", mode, 2'd2);
        bus_wr_op(4'h7, 8'hFF);
        check("R2 other address keeps mode", mode, 2'd2);
        check("R2 other address no request", req_rel, 1'b0);

        // R4
        bus_wr_op(4'h2, 8'h01);
        check("R4 valid low", max_hold, 1'b0);
        valid = 1'b1;
        #1;
        check("R4 valid high", max_hold, 1'b1);
        check("R3 mode normal", mode, 2'd0);
        valid = 1'b0;
        bus_wr_op(4'h2, 8'h00);

        // R5, R6, R9, R11: write
        wr_q.push_back(8'hA5);
        bus_wr_op(4'h3, 8'hA5);
        check("R5 request raised", req_rel, 1'b1);
        far_pull = 1'b1; sync = 1'b1;
        repeat (3) @(negedge clk);
        check("R6 no grant with sync high", grant_n, 1'b1);
        check("R9 idle serial low", mem_ser_o, 1'b0);
        serve(8'h00, 1'b0);

        // R8, R11: reads
        bus_rd_op(4'h3, 8'h3C);
        check("R5 request on read", req_rel, 1'b1);
        serve(8'h3C, 1'b1);
        bus_rd_op(4'h3, 8'hC1);
        serve(8'hC1, 1'b1);

        // R12: strobes while pending are ignored
        wr_q.push_back(8'h5A);
        bus_wr_op(4'h3, 8'h5A);
        bus_wr_op(4'h3, 8'hFF);
        @(negedge clk);
        bus_addr = 4'h3; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        serve(8'h99, 1'b0);
        check("R12 no extra request", req_rel, 1'b0);

        // R10: max-hold source
        bus_wr_op(4'h2, 8'h01);
        valid = 1'b1; mh_ser = 1'b1;
        wr_q.push_back(8'hFF);
        bus_wr_op(4'h3, 8'h00);
        serve(8'h00, 1'b0);
        valid = 1'b0; mh_ser = 1'b0;

        repeat (3) @(negedge clk);
        check("R11 read scoreboard drained", rd_q.size(), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule